// File: doc/BRIEF.md
# Receive Scatter-Gather Packet Splitter

This block is the stream-to-memory side of a descriptor-chained DMA channel. It accepts the byte length of one incoming packet and spreads that packet over a linked list of receive descriptors held in word-addressed memory. Each descriptor's buffer takes as many of the remaining bytes as its length field allows. For each buffer it issues one payload move request (address and byte count); the payload bytes themselves are moved by a separate datapath. It then writes back a status word that marks completion, the byte count, and whether the descriptor opened or closed the packet. The descriptor that takes the final byte also receives five application words that arrived earlier on a side control channel.

A descriptor occupies nine consecutive words starting at its pointer. Offset 0 holds the next-descriptor pointer, offset 1 the buffer address, offset 2 the control word (buffer length in bits 22:0), offset 3 the status word, and offsets 4 to 8 the application words. Software loads the current pointer, which clears the halted flag. It loads the tail pointer, which clears the idle flag. It holds `run` high and then offers packets. Two interfaces are valid/ready. On the packet-length input, back-pressure lasts until the channel is free to start a packet. On the payload request output, the block keeps address and length stable while `xfer_ready` is low. The application-word input never applies back-pressure.

Top module: `rxsg_splitter`

## Requirements
- R1: Application words are taken on every cycle with `app_valid` high (`app_ready` is always 1). The k-th word of each group of five goes to slot k, and a later group overwrites an earlier one.
- R2: Each used descriptor issues one payload request with address = its buffer word and length = min(control bits 22:0, bytes remaining). While `xfer_ready` is low, `xfer_valid`, `xfer_addr` and `xfer_len` stay stable.
- R3: Status bit 27 is set only in the first descriptor used for a packet.
- R4: The descriptor that takes the last byte has status bit 26 set, and the five latched application words are written to its offsets 4 to 8 in slot order.
- R5: Every used descriptor's status word is written back with bit 31 set and its byte count in bits 22:0; all other bits are zero.
- R6: A fetched descriptor whose status bit 31 is already set is left unwritten. The block sets `halted`, does not advance the current pointer, and ends the packet.
- R7: After each used descriptor, the current pointer takes that descriptor's next pointer. If the finished descriptor was the tail, `idle` is set and the packet ends even if bytes remain; descriptors after the stop point are not touched.
- R8: `pkt_ready` is low while `run` is low, while `halted` or `idle` is set, and while a packet is in progress.
- R9: Each packet ends with a one-cycle `pkt_end` pulse. `pkt_bytes` gives the bytes placed, and `pkt_ovf` is set exactly when fewer than the offered bytes were placed.
- R10: After reset, `halted` is 1 and `idle` is 0. Loading the current pointer clears `halted`, and loading the tail pointer clears `idle`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Channel enable |
| cur_wr | input | 1 | Load current descriptor pointer |
| cur_din | input | AW | Current pointer value |
| tail_wr | input | 1 | Load tail descriptor pointer |
| tail_din | input | AW | Tail pointer value |
| app_valid | input | 1 | Application word valid |
| app_ready | output | 1 | Application word ready (always 1) |
| app_data | input | 32 | Application word |
| pkt_valid | input | 1 | Packet length valid |
| pkt_ready | output | 1 | Packet length ready |
| pkt_len | input | LW | Packet length in bytes |
| mem_req | output | 1 | Descriptor memory access |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW | Descriptor memory word address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, one cycle after a read request |
| xfer_valid | output | 1 | Payload move request valid |
| xfer_ready | input | 1 | Payload move request accepted |
| xfer_addr | output | 32 | Buffer address of the move |
| xfer_len | output | LW | Byte count of the move |
| pkt_end | output | 1 | One-cycle end-of-packet pulse |
| pkt_bytes | output | LW | Bytes placed for the ended packet |
| pkt_ovf | output | 1 | Bytes were dropped |
| halted | output | 1 | Channel halted |
| idle | output | 1 | Tail descriptor reached |
| cur_ptr | output | AW | Current descriptor pointer |

## Verification
The assertions check properties that must hold on every cycle. Packet acceptance is gated by `run`, `halted` and `idle`. A stalled payload request stays stable. No request or reported byte count exceeds the accepted packet length. The overflow flag agrees with the reported count, and a rise of `halted` comes with a packet end. Only the bench scenarios show the contents of the memory words written back: the first and last markers, the per-descriptor byte split, the application-word copy, and the descriptors left untouched. They also show where the current pointer lands after a tail stop, after an exact fit, after a zero-length buffer, and after hitting an already-completed descriptor.

// File: rtl/rxsg_pkg.sv
package rxsg_pkg;
  localparam int OFF_NEXT  = 0;
  localparam int OFF_BUF   = 1;
  localparam int OFF_CTRL  = 2;
  localparam int OFF_STAT  = 3;
  localparam int OFF_APP   = 4;
  localparam int HDR_WORDS = 4;
  localparam int BIT_DONE  = 31;
  localparam int BIT_FIRST = 27;
  localparam int BIT_LAST  = 26;

  typedef enum logic [2:0] {
    ST_WAIT,
    ST_FETCH,
    ST_MOVE,
    ST_STATUS,
    ST_APPW,
    ST_STEP
  } sg_state_e;
endpackage

// File: rtl/rxsg_app_store.sv
module rxsg_app_store #(
  parameter int N = 5,
  parameter int W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [W-1:0]      in_data,
  output logic [N-1:0][W-1:0] words
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  logic [IW-1:0] slot;

  assign in_ready = 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot <= '0;
    end else if (in_valid) begin
      slot <= (slot == IW'(N - 1)) ? '0 : slot + 1'b1;
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_slot
    logic [W-1:0] word_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        word_q <= '0;
      end else if (in_valid && slot == IW'(g)) begin
        word_q <= in_data;
      end
    end
    assign words[g] = word_q;
  end
endmodule

// File: rtl/rxsg_chunk.sv
module rxsg_chunk #(
  parameter int LW = 23
) (
  input  logic [LW-1:0] cap,
  input  logic [LW-1:0] remain,
  output logic [LW-1:0] take,
  output logic          is_last
);
  always_comb begin
    is_last = (cap >= remain);
    take    = is_last ? remain : cap;
  end
endmodule

// File: rtl/rxsg_ctrl.sv
module rxsg_ctrl
  import rxsg_pkg::*;
#(
  parameter int AW   = 16,
  parameter int LW   = 23,
  parameter int NAPP = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 run,
  input  logic                 cur_wr,
  input  logic [AW-1:0]        cur_din,
  input  logic                 tail_wr,
  input  logic [AW-1:0]        tail_din,
  input  logic                 pkt_valid,
  output logic                 pkt_ready,
  input  logic [LW-1:0]        pkt_len,
  input  logic [NAPP-1:0][31:0] app_words,
  output logic                 mem_req,
  output logic                 mem_we,
  output logic [AW-1:0]        mem_addr,
  output logic [31:0]          mem_wdata,
  input  logic [31:0]          mem_rdata,
  output logic                 xfer_valid,
  input  logic                 xfer_ready,
  output logic [31:0]          xfer_addr,
  output logic [LW-1:0]        xfer_len,
  output logic [LW-1:0]        buf_len,
  output logic [LW-1:0]        remain_o,
  input  logic [LW-1:0]        chunk,
  input  logic                 chunk_last,
  output logic                 pkt_end,
  output logic [LW-1:0]        pkt_bytes,
  output logic                 pkt_ovf,
  output logic                 halted,
  output logic                 idle,
  output logic [AW-1:0]        cur_ptr
);
  localparam int CMAX = (NAPP > HDR_WORDS) ? NAPP : HDR_WORDS;
  localparam int CW   = $clog2(CMAX + 1);

  sg_state_e     state;
  logic [CW-1:0] cnt;
  logic [AW-1:0] cur_q, tail_q;
  logic [31:0]   d_next, d_buf, d_ctrl;
  logic [LW-1:0] remain_q, placed_q, chunk_q;
  logic          first_q, last_q;
  logic [31:0]   stat_word;

  assign pkt_ready  = (state == ST_WAIT) && run && !halted && !idle;
  assign xfer_valid = (state == ST_MOVE);
  assign xfer_addr  = d_buf;
  assign xfer_len   = chunk_q;
  assign buf_len    = d_ctrl[LW-1:0];
  assign remain_o   = remain_q;
  assign cur_ptr    = cur_q;

  always_comb begin
    stat_word            = '0;
    stat_word[BIT_DONE]  = 1'b1;
    stat_word[BIT_FIRST] = first_q;
    stat_word[BIT_LAST]  = last_q;
    stat_word[LW-1:0]    = chunk_q;
  end

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = cur_q;
    mem_wdata = '0;
    case (state)
      ST_FETCH: begin
        if (cnt < CW'(HDR_WORDS)) begin
          mem_req  = 1'b1;
          mem_addr = cur_q + AW'(cnt);
        end
      end
      ST_STATUS: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = cur_q + AW'(OFF_STAT);
        mem_wdata = stat_word;
      end
      ST_APPW: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = cur_q + AW'(OFF_APP) + AW'(cnt);
        mem_wdata = app_words[cnt];
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_WAIT;
      cnt      <= '0;
      cur_q    <= '0;
      tail_q   <= '0;
      d_next   <= '0;
      d_buf    <= '0;
      d_ctrl   <= '0;
      remain_q <= '0;
      placed_q <= '0;
      chunk_q  <= '0;
      first_q  <= 1'b0;
      last_q   <= 1'b0;
      pkt_end  <= 1'b0;
      pkt_bytes <= '0;
      pkt_ovf  <= 1'b0;
      halted   <= 1'b1;
      idle     <= 1'b0;
    end else begin
      pkt_end <= 1'b0;
      case (state)
        ST_WAIT: begin
          if (cur_wr) begin
            cur_q  <= cur_din;
            halted <= 1'b0;
          end
          if (tail_wr) begin
            tail_q <= tail_din;
            idle   <= 1'b0;
          end
          if (pkt_valid && pkt_ready) begin
            remain_q <= pkt_len;
            placed_q <= '0;
            first_q  <= 1'b1;
            cnt      <= '0;
            state    <= ST_FETCH;
          end
        end
        ST_FETCH: begin
          cnt <= cnt + 1'b1;
          case (cnt)
            CW'(OFF_NEXT + 1): d_next <= mem_rdata;
            CW'(OFF_BUF + 1):  d_buf  <= mem_rdata;
            CW'(OFF_CTRL + 1): d_ctrl <= mem_rdata;
            CW'(OFF_STAT + 1): begin
              cnt <= '0;
              if (mem_rdata[BIT_DONE]) begin
                halted    <= 1'b1;
                pkt_end   <= 1'b1;
                pkt_bytes <= placed_q;
                pkt_ovf   <= (remain_q != '0);
                state     <= ST_WAIT;
              end else begin
                chunk_q <= chunk;
                last_q  <= chunk_last;
                state   <= ST_MOVE;
              end
            end
            default: ;
          endcase
        end
        ST_MOVE: begin
          if (xfer_ready) begin
            placed_q <= placed_q + chunk_q;
            remain_q <= remain_q - chunk_q;
            state    <= ST_STATUS;
          end
        end
        ST_STATUS: begin
          cnt   <= '0;
          state <= last_q ? ST_APPW : ST_STEP;
        end
        ST_APPW: begin
          cnt <= cnt + 1'b1;
          if (cnt == CW'(NAPP - 1)) begin
            state <= ST_STEP;
          end
        end
        ST_STEP: begin
          cur_q   <= d_next[AW-1:0];
          first_q <= 1'b0;
          cnt     <= '0;
          if (cur_q == tail_q) begin
            idle <= 1'b1;
          end
          if (last_q || cur_q == tail_q) begin
            pkt_end   <= 1'b1;
            pkt_bytes <= placed_q;
            pkt_ovf   <= (remain_q != '0);
            state     <= ST_WAIT;
          end else begin
            state <= ST_FETCH;
          end
        end
        default: state <= ST_WAIT;
      endcase
    end
  end
endmodule

// File: rtl/rxsg_splitter.sv
module rxsg_splitter #(
  parameter int AW = 16,
  parameter int LW = 23
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          cur_wr,
  input  logic [AW-1:0] cur_din,
  input  logic          tail_wr,
  input  logic [AW-1:0] tail_din,
  input  logic          app_valid,
  output logic          app_ready,
  input  logic [31:0]   app_data,
  input  logic          pkt_valid,
  output logic          pkt_ready,
  input  logic [LW-1:0] pkt_len,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata,
  output logic          xfer_valid,
  input  logic          xfer_ready,
  output logic [31:0]   xfer_addr,
  output logic [LW-1:0] xfer_len,
  output logic          pkt_end,
  output logic [LW-1:0] pkt_bytes,
  output logic          pkt_ovf,
  output logic          halted,
  output logic          idle,
  output logic [AW-1:0] cur_ptr
);
  localparam int NAPP = 5;

  logic [NAPP-1:0][31:0] app_words;
  logic [LW-1:0]         buf_len, remain, chunk;
  logic                  chunk_last;

  rxsg_app_store #(.N(NAPP), .W(32)) u_app (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (app_valid),
    .in_ready (app_ready),
    .in_data  (app_data),
    .words    (app_words)
  );

  rxsg_chunk #(.LW(LW)) u_chunk (
    .cap     (buf_len),
    .remain  (remain),
    .take    (chunk),
    .is_last (chunk_last)
  );

  rxsg_ctrl #(.AW(AW), .LW(LW), .NAPP(NAPP)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (run),
    .cur_wr     (cur_wr),
    .cur_din    (cur_din),
    .tail_wr    (tail_wr),
    .tail_din   (tail_din),
    .pkt_valid  (pkt_valid),
    .pkt_ready  (pkt_ready),
    .pkt_len    (pkt_len),
    .app_words  (app_words),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_rdata  (mem_rdata),
    .xfer_valid (xfer_valid),
    .xfer_ready (xfer_ready),
    .xfer_addr  (xfer_addr),
    .xfer_len   (xfer_len),
    .buf_len    (buf_len),
    .remain_o   (remain),
    .chunk      (chunk),
    .chunk_last (chunk_last),
    .pkt_end    (pkt_end),
    .pkt_bytes  (pkt_bytes),
    .pkt_ovf    (pkt_ovf),
    .halted     (halted),
    .idle       (idle),
    .cur_ptr    (cur_ptr)
  );
endmodule

// File: rtl/rxsg_splitter_chk.sv
module rxsg_splitter_chk #(
  parameter int LW = 23
) (
  input logic          clk,
  input logic          rst_n,
  input logic          run,
  input logic          pkt_valid,
  input logic          pkt_ready,
  input logic [LW-1:0] pkt_len,
  input logic          xfer_valid,
  input logic          xfer_ready,
  input logic [31:0]   xfer_addr,
  input logic [LW-1:0] xfer_len,
  input logic          pkt_end,
  input logic [LW-1:0] pkt_bytes,
  input logic          pkt_ovf,
  input logic          halted,
  input logic          idle
);
  logic [LW-1:0] offered;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      offered <= '0;
    end else if (pkt_valid && pkt_ready) begin
      offered <= pkt_len;
    end
  end

  AST_READY_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_ready |-> (run && !halted && !idle)); // R8

  AST_XFER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && !xfer_ready) |=> (xfer_valid && $stable(xfer_addr) && $stable(xfer_len))); // R2

  AST_XFER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid |-> (xfer_len <= offered)); // R2

  AST_BYTES_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_end |-> (pkt_bytes <= offered)); // R9

  AST_OVF_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_end |-> (pkt_ovf == (pkt_bytes != offered))); // R9

  AST_HALT_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(halted) |-> pkt_end); // R6

  AST_NO_READY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid |-> !pkt_ready); // R8
endmodule

bind rxsg_splitter rxsg_splitter_chk #(.LW(LW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .run        (run),
  .pkt_valid  (pkt_valid),
  .pkt_ready  (pkt_ready),
  .pkt_len    (pkt_len),
  .xfer_valid (xfer_valid),
  .xfer_ready (xfer_ready),
  .xfer_addr  (xfer_addr),
  .xfer_len   (xfer_len),
  .pkt_end    (pkt_end),
  .pkt_bytes  (pkt_bytes),
  .pkt_ovf    (pkt_ovf),
  .halted     (halted),
  .idle       (idle)
);

// File: tb/rxsg_splitter_test.sv
module rxsg_splitter_test;
  localparam int AW = 8;
  localparam int LW = 23;
  localparam int BASE0 = 16;
  localparam int STRIDE = 16;
  localparam int SPARE = 80;
  // plen, len0..len3, tail index, expected bytes, expected ovf, expected used
  localparam int VEC [7][9] = '{
    '{100, 40, 40, 40, 40, 3, 100, 0, 3},
    '{ 40, 64, 64, 64, 64, 3,  40, 0, 1},
    '{200, 50, 50, 50, 20, 3, 170, 1, 4},
    '{ 60, 30, 30, 30, 30, 1,  60, 0, 2},
    '{  0, 16, 16, 16, 16, 3,   0, 0, 1},
    '{ 50,  0, 50, 50, 50, 3,  50, 0, 2},
    '{ 90, 30, 30, 30, 30, 1,  60, 1, 2}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run = 1'b0;
  logic cur_wr = 1'b0, tail_wr = 1'b0;
  logic [AW-1:0] cur_din = '0, tail_din = '0;
  logic app_valid = 1'b0, app_ready;
  logic [31:0] app_data = '0;
  logic pkt_valid = 1'b0, pkt_ready;
  logic [LW-1:0] pkt_len = '0;
  logic mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;
  logic xfer_valid, xfer_ready = 1'b1;
  logic [31:0] xfer_addr;
  logic [LW-1:0] xfer_len;
  logic pkt_end, pkt_ovf, halted, idle;
  logic [LW-1:0] pkt_bytes;
  logic [AW-1:0] cur_ptr;

  logic [31:0] mem [0:255];
  logic tb_we = 1'b0;
  logic [AW-1:0] tb_a = '0;
  logic [31:0] tb_d = '0;
  logic log_clr = 1'b0;
  int nlog;
  logic [31:0] lg_addr [0:15];
  logic [LW-1:0] lg_len [0:15];

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  rxsg_splitter #(.AW(AW), .LW(LW)) uut (.*);

  always @(posedge clk) begin
    if (tb_we) mem[tb_a] <= tb_d;
    else if (mem_req) begin
      if (mem_we) mem[mem_addr] <= mem_wdata;
      else mem_rdata <= mem[mem_addr];
    end
  end

  always @(posedge clk) begin
    if (log_clr) nlog <= 0;
    else if (xfer_valid && xfer_ready && nlog < 16) begin
      lg_addr[nlog] <= xfer_addr;
      lg_len[nlog]  <= xfer_len;
      nlog <= nlog + 1;
    end
  end

  initial forever begin
    @(negedge clk);
    xfer_ready = ~xfer_ready;
  end

  task automatic chk(string req, string what, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic poke(int a, logic [31:0] d);
    @(negedge clk);
    tb_we = 1'b1; tb_a = AW'(a); tb_d = d;
    @(negedge clk);
    tb_we = 1'b0;
  endtask

  task automatic build_chain(int l0, int l1, int l2, int l3, logic [31:0] st0);
    int lens [4];
    lens = '{l0, l1, l2, l3};
    for (int k = 0; k < 4; k++) begin
      int b = BASE0 + STRIDE * k;
      poke(b, (k < 3) ? 32'(b + STRIDE) : 32'(SPARE));
      poke(b + 1, 32'h1000 * (k + 1));
      poke(b + 2, 32'(lens[k]));
      poke(b + 3, (k == 0) ? st0 : 32'h0);
      for (int j = 0; j < 5; j++) poke(b + 4 + j, 32'h0);
    end
  endtask

  task automatic arm(int tail_idx);
    @(negedge clk);
    cur_wr = 1'b1; cur_din = AW'(BASE0);
    @(negedge clk);
    cur_wr = 1'b0;
    tail_wr = 1'b1; tail_din = AW'(BASE0 + STRIDE * tail_idx);
    @(negedge clk);
    tail_wr = 1'b0;
  endtask

  task automatic send_app(logic [31:0] seed);
    for (int j = 0; j < 5; j++) begin
      @(negedge clk);
      app_valid = 1'b1; app_data = seed + 32'(j);
    end
    @(negedge clk);
    app_valid = 1'b0;
  endtask

  task automatic send_pkt(int len, output int bytes, output bit ovf);
    @(negedge clk);
    log_clr = 1'b1;
    @(negedge clk);
    log_clr = 1'b0;
    pkt_valid = 1'b1; pkt_len = LW'(len);
    while (!pkt_ready) @(negedge clk);
    @(negedge clk);
    pkt_valid = 1'b0;
    bytes = -1; ovf = 1'b0;
    for (int t = 0; t < 2000; t++) begin
      if (pkt_end) begin
        bytes = int'(pkt_bytes); ovf = pkt_ovf;
        break;
      end
      @(negedge clk);
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int bytes;
    bit ovf;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    run = 1'b1;
    @(negedge clk);
    chk("R10", "halted after reset", halted, 1);
    chk("R10", "idle after reset", idle, 0);
    chk("R10", "ready after reset", pkt_ready, 0);
    chk("R9", "no end after reset", pkt_end, 0);

    build_chain(40, 40, 40, 40, 32'h0);
    arm(3);
    chk("R10", "cur load clears halted", halted, 0);
    run = 1'b0;
    @(negedge clk);
    chk("R8", "ready low while run low", pkt_ready, 0);
    run = 1'b1;
    @(negedge clk);
    chk("R8", "ready high when armed", pkt_ready, 1);

    for (int v = 0; v < 7; v++) begin
      logic [31:0] seed;
      int rem, used;
      bit stop;
      seed = 32'hA000_0000 + 32'(v * 256);
      build_chain(VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4], 32'h0);
      arm(VEC[v][5]);
      send_app(seed);
      send_pkt(VEC[v][0], bytes, ovf);
      chk("R9", "bytes placed", bytes, VEC[v][6]);
      chk("R9", "overflow flag", ovf, VEC[v][7]);
      chk("R2", "request count", nlog, VEC[v][8]);
      rem = VEC[v][0]; used = 0; stop = 1'b0;
      for (int k = 0; k < 4 && !stop; k++) begin
        int b, c;
        bit last;
        logic [31:0] es;
        b = BASE0 + STRIDE * k;
        c = (VEC[v][1 + k] < rem) ? VEC[v][1 + k] : rem;
        rem -= c;
        last = (rem == 0);
        es = 32'h8000_0000 | 32'(c);
        if (k == 0) es |= 32'h0800_0000;
        if (last) es |= 32'h0400_0000;
        chk("R5", "status word (R3 first, R4 last)", mem[b + 3], es);
        if (k < 16) begin
          chk("R2", "request addr", lg_addr[k], 32'h1000 * (k + 1));
          chk("R2", "request len", lg_len[k], c);
        end
        if (last)
          for (int j = 0; j < 5; j++)
            chk("R4", "app word on last", mem[b + 4 + j], seed + 32'(j));
        used++;
        stop = last || (k == VEC[v][5]);
      end
      if (used < 4) chk("R7", "next descriptor untouched", mem[BASE0 + STRIDE * used + 3], 0);
      chk("R7", "current pointer advanced", cur_ptr, (used < 4) ? BASE0 + STRIDE * used : SPARE);
      chk("R7", "idle on tail", idle, (used - 1 == VEC[v][5]));
      if (used - 1 == VEC[v][5]) chk("R8", "ready low while idle", pkt_ready, 0);
    end

    arm(3);
    chk("R10", "tail load clears idle", idle, 0);

    build_chain(40, 40, 40, 40, 32'h8000_0000);
    arm(3);
    send_app(32'h5500_0000);
    send_pkt(10, bytes, ovf);
    chk("R6", "bytes on completed desc", bytes, 0);
    chk("R6", "ovf on completed desc", ovf, 1);
    chk("R6", "halted set", halted, 1);
    chk("R6", "pointer held", cur_ptr, BASE0);
    chk("R6", "status untouched", mem[BASE0 + 3], 32'h8000_0000);
    chk("R6", "no payload request", nlog, 0);
    chk("R8", "ready low while halted", pkt_ready, 0);

    build_chain(40, 40, 40, 40, 32'h0);
    arm(3);
    send_app(32'h1100_0000);
    send_app(32'h2200_0000);
    send_pkt(40, bytes, ovf);
    for (int j = 0; j < 5; j++)
      chk("R1", "later group wins", mem[BASE0 + 4 + j], 32'h2200_0000 + 32'(j));
    chk("R1", "app ready", app_ready, 1);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule